// File: doc/BRIEF.md
# Reset Cause Register

This block holds a single 32-bit status and control word that tells software why the system last came out of reset, and lets software ask for a new reset. Five bits at the top of the word carry the causes: power-on, software-requested power-on, software-requested external-initiate, and two button causes. The remaining 27 bits are always zero.

Each of these bits follows its own write rule. The hardware-cause bits (power-on and both button causes) are cleared by writing one to them. The two software bits take the written value directly. Writing a one to either software bit sends a one-cycle request to the reset network. A small saturating counter counts system resets since power-up. The power-on cause is latched only when a system reset arrives while that counter is zero. A software power-on request clears the counter, so the next system reset latches the power-on cause again.

The register sits at offset 0xf020 and is reached through the upper word, so the decoded address is 0xf024. Reads are combinational.

Top module: `rst_cause_reg`

## Requirements
- R1: While `pwrRstN` is low, and right after it rises, the register reads 0x00000000 and `rstReq` is 0.
- R2: A `sysRst` pulse while the reset counter is zero loads the register with exactly 0x80000000 (bit 31 only). It also increments the counter.
- R3: A `sysRst` pulse while the counter is non-zero leaves the register unchanged.
- R4: Writing a one to bit 31, bit 28 or bit 27 clears that bit. Writing zero to any of these bits leaves it as it was.
- R5: Bit 30 (software power-on) and bit 29 (software external-initiate) take the written data value on every register write.
- R6: Bits 26:0 always read zero. Data written to them has no effect.
- R7: A register write with bit 30 set clears the reset counter. It also makes `rstReq` high in the cycle after the write, so the next `sysRst` loads 0x80000000 again.
- R8: A register write with bit 29 set and bit 30 clear makes `rstReq` high in the cycle after the write, and it does not clear the counter.
- R9: `btnPor` sets bit 28 and `btnXir` sets bit 27. When a write clears one of these bits in the same cycle that its button input is high, the set wins.
- R10: Only address 0xf024 (offset 0xf020 with address bit 2 set) selects the register. A write to any other address has no effect, and a read from any other address returns 0.
- R11: When `sysRst` and a register write occur in the same cycle, the write is ignored and raises no request.
- R12: `rstReq` lasts exactly one cycle for each triggering write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwrRstN | input | 1 | Asynchronous power-up reset, active low |
| sysRst | input | 1 | System reset event, one cycle per event |
| btnPor | input | 1 | Button power-on reset event |
| btnXir | input | 1 | Button external-initiate reset event |
| wrEn | input | 1 | Register write strobe |
| addr | input | 16 | Byte address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from `addr` |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
Every register effect (a write rule, a button set, a `sysRst` load) is visible one clock edge after the stimulus. `rstReq` also rises one edge after the triggering write and must fall again on the edge after that. The bench drives each stimulus on a falling edge and samples `rstReq` on the next falling edge. It then switches `addr` to the register and compares `rdData` a moment later, so the readback reflects exactly one update. After each expected pulse, one idle cycle confirms that the request has dropped.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int DATA_W   = 32;
  localparam int BIT_POR  = 31;
  localparam int BIT_SPOR = 30;
  localparam int BIT_SXIR = 29;
  localparam int BIT_BPOR = 28;
  localparam int BIT_BXIR = 27;
  localparam logic [DATA_W-1:0] LIVE_MASK = 32'hf800_0000;
  localparam logic [DATA_W-1:0] W1C_MASK  = 32'h9800_0000;
  localparam logic [DATA_W-1:0] DIR_MASK  = 32'h6000_0000;
  localparam logic [DATA_W-1:0] POR_VALUE = 32'h8000_0000;

  typedef struct packed {
    logic              apply;    // accepted register write this cycle
    logic              cntClr;   // software power-on: restart counter
    logic [DATA_W-1:0] data;     // write data already masked to live bits
    logic              rdSel;    // read address hits the register
  } rcc_strobe_t;
endpackage

// File: rtl/rcc_ctrl.sv
module rcc_ctrl
  import rcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 16'hf020
) (
  input  logic              clk,
  input  logic              pwrRstN,
  input  logic              sysRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output rcc_strobe_t       strobe,
  output logic              rstReq
);
  logic addrHit;
  logic wrAccept;
  logic reqNext;
  logic reqQ;

  // upper word of the doubleword at REG_OFFSET
  assign addrHit  = (addr[ADDR_W-1:3] == REG_OFFSET[ADDR_W-1:3]) && addr[2];
  assign wrAccept = wrEn && addrHit && !sysRst;
  assign reqNext  = wrAccept && (wrData[BIT_SPOR] || wrData[BIT_SXIR]);

  always_comb begin
    strobe.apply  = wrAccept;
    strobe.cntClr = wrAccept && wrData[BIT_SPOR];
    strobe.data   = wrData & LIVE_MASK;
    strobe.rdSel  = addrHit;
  end

  always_ff @(posedge clk or negedge pwrRstN) begin
    if (!pwrRstN) reqQ <= 1'b0;
    else          reqQ <= reqNext;
  end

  assign rstReq = reqQ;

  // R7 R8: a request always follows an accepted software write
  assert_req_cause_R8: assert property (@(posedge clk) disable iff (!pwrRstN)
    rstReq |-> $past(wrEn && addrHit && !sysRst && (wrData[BIT_SPOR] || wrData[BIT_SXIR])));
  // R11: write during system reset never requests
  assert_sysrst_blocks_R11: assert property (@(posedge clk) disable iff (!pwrRstN)
    sysRst |=> !rstReq);
endmodule

// File: rtl/rcc_datapath.sv
module rcc_datapath
  import rcc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              pwrRstN,
  input  logic              sysRst,
  input  logic              btnPor,
  input  logic              btnXir,
  input  rcc_strobe_t       strobe,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0] causeQ, causeNext, afterWr, btnSet;
  logic [CNT_W-1:0]  cntQ, cntNext;

  always_comb begin
    btnSet = '0;
    btnSet[BIT_BPOR] = btnPor;
    btnSet[BIT_BXIR] = btnXir;
  end

  always_comb begin
    afterWr = causeQ;
    if (strobe.apply) begin
      afterWr = (causeQ & ~(strobe.data & W1C_MASK) & ~DIR_MASK)
              | (strobe.data & DIR_MASK);
    end
    if (sysRst) begin
      causeNext = (cntQ == '0) ? POR_VALUE : causeQ;
    end else begin
      causeNext = (afterWr | btnSet) & LIVE_MASK;
    end
  end

  always_comb begin
    cntNext = cntQ;
    if (sysRst) begin
      if (cntQ != CNT_MAX) cntNext = cntQ + 1'b1;
    end else if (strobe.cntClr) begin
      cntNext = '0;
    end
  end

  always_ff @(posedge clk or negedge pwrRstN) begin
    if (!pwrRstN) begin
      causeQ <= '0;
      cntQ   <= '0;
    end else begin
      causeQ <= causeNext;
      cntQ   <= cntNext;
    end
  end

  assign rdData = strobe.rdSel ? causeQ : '0;

  assert_first_load_R2: assert property (@(posedge clk) disable iff (!pwrRstN)
    (sysRst && cntQ == '0) |=> causeQ == POR_VALUE);
  assert_later_keep_R3: assert property (@(posedge clk) disable iff (!pwrRstN)
    (sysRst && cntQ != '0) |=> $stable(causeQ));
  assert_low_zero_R6: assert property (@(posedge clk) disable iff (!pwrRstN)
    causeQ[BIT_BXIR-1:0] == '0);
  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!pwrRstN)
    (strobe.cntClr && !sysRst) |=> cntQ == '0);
  assert_btn_set_R9: assert property (@(posedge clk) disable iff (!pwrRstN)
    (btnPor && !sysRst) |=> causeQ[BIT_BPOR]);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 16'hf020,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              pwrRstN,
  input  logic              sysRst,
  input  logic              btnPor,
  input  logic              btnXir,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              rstReq
);
  rcc_strobe_t strobe;

  rcc_ctrl #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_ctrl (
    .clk(clk), .pwrRstN(pwrRstN), .sysRst(sysRst), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .strobe(strobe), .rstReq(rstReq)
  );

  rcc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .pwrRstN(pwrRstN), .sysRst(sysRst), .btnPor(btnPor),
    .btnXir(btnXir), .strobe(strobe), .rdData(rdData)
  );
endmodule

// File: tb/sim_rst_cause_reg.sv
module sim_rst_cause_reg;
  localparam logic [15:0] REG_ADDR = 16'hf024;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [31:0] data;
    logic        bp;
    logic        bx;
    logic        sr;
    logic [31:0] expReg;
    logic        expReq;
    logic [3:0]  reqId;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 16'hf024, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 4'd2},  // R2 first load
    '{1'b0, 16'hf024, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 4'd3},  // R3 second reset keeps
    '{1'b1, 16'hf024, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 4'd4},  // R4 clear bit 31
    '{1'b0, 16'hf024, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h1000_0000, 1'b0, 4'd9},  // R9 button por
    '{1'b0, 16'hf024, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 32'h1800_0000, 1'b0, 4'd9},  // R9 button xir
    '{1'b1, 16'hf024, 32'h0800_0000, 1'b0, 1'b1, 1'b0, 32'h1800_0000, 1'b0, 4'd9},  // R9 set beats clear
    '{1'b1, 16'hf024, 32'h1000_0000, 1'b0, 1'b0, 1'b0, 32'h0800_0000, 1'b0, 4'd4},  // R4 clear bit 28 only
    '{1'b1, 16'hf024, 32'h2000_0000, 1'b0, 1'b0, 1'b0, 32'h2800_0000, 1'b1, 4'd8},  // R8 soft xir
    '{1'b0, 16'hf024, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h2800_0000, 1'b0, 4'd8},  // R8 counter kept
    '{1'b1, 16'hf024, 32'h4000_0000, 1'b0, 1'b0, 1'b0, 32'h4800_0000, 1'b1, 4'd5},  // R5 R7 direct write
    '{1'b0, 16'hf024, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 4'd7},  // R7 reload after clear
    '{1'b1, 16'hf024, 32'h07ff_ffff, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 4'd6},  // R6 low bits ignored
    '{1'b1, 16'hf020, 32'hffff_ffff, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 4'd10}, // R10 lower word ignored
    '{1'b1, 16'hf024, 32'h6000_0000, 1'b0, 1'b0, 1'b0, 32'he000_0000, 1'b1, 4'd7},  // R7 both soft bits
    '{1'b1, 16'hf024, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 4'd11}  // R11 write lost to sysRst
  };

  logic clk = 1'b0;
  logic pwrRstN, sysRst, btnPor, btnXir, wrEn, rstReq;
  logic [15:0] addr;
  logic [31:0] wrData, rdData;
  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_cause_reg u0 (
    .clk(clk), .pwrRstN(pwrRstN), .sysRst(sysRst), .btnPor(btnPor),
    .btnXir(btnXir), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rstReq(rstReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 1'b0; sysRst = 1'b0; btnPor = 1'b0; btnXir = 1'b0;
    wrData = '0; addr = REG_ADDR;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    for (int cyc = 0; cyc < 20000; cyc++) @(posedge clk);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    idle();
    pwrRstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reg in reset", rdData, 32'h0);
    check("R1 req in reset", {31'b0, rstReq}, 32'h0);
    pwrRstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1 reg after reset", rdData, 32'h0);
    check("R1 req after reset", {31'b0, rstReq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wrEn = TBL[i].wr; addr = TBL[i].addr; wrData = TBL[i].data;
      btnPor = TBL[i].bp; btnXir = TBL[i].bx; sysRst = TBL[i].sr;
      @(negedge clk);
      check($sformatf("R%0d vec %0d req", TBL[i].reqId, i), {31'b0, rstReq}, {31'b0, TBL[i].expReq});
      idle();
      #1;
      check($sformatf("R%0d vec %0d reg", TBL[i].reqId, i), rdData, TBL[i].expReg);
      if (TBL[i].expReq) begin
        @(negedge clk);
        check($sformatf("R12 vec %0d pulse ends", i), {31'b0, rstReq}, 32'h0);
      end
    end

    // R10: read from a non-register address returns zero
    addr = 16'hf020; #1;
    check("R10 read lower word", rdData, 32'h0);
    addr = 16'h1024; #1;
    check("R10 read other offset", rdData, 32'h0);
    addr = REG_ADDR;

    // R5: writing zero to bits 30/29 clears them; w1c bit untouched by zero
    wrEn = 1'b1; wrData = 32'h0; @(negedge clk); idle(); #1;
    check("R5 soft bits cleared by zero write", rdData, 32'h8000_0000);

    // R1: power-up reset mid-run restores zero and counter
    pwrRstN = 1'b0; @(negedge clk); pwrRstN = 1'b1; @(negedge clk); #1;
    check("R1 second power-up", rdData, 32'h0);
    sysRst = 1'b1; @(negedge clk); idle(); #1;
    check("R2 load after power-up", rdData, 32'h8000_0000);

    done = 1'b1;
    finish_run();
  end
endmodule